// File: doc/BRIEF.md
# Reset and Stall Sequencing Controller

This block sits between the chip-level control pins and a motion estimation engine. It turns an active-low synchronous reset request into an internal reset. That internal reset stays active for a fixed tail after the request is released. The block also turns an active-low clock enable into a registered hold that freezes the datapath for one cycle per sampled disable.

The block guards the execution start strobe. A strobe is forwarded to the datapath only after a minimum number of running cycles has passed since the internal reset ended. A strobe that arrives during reset, or too early after it, is dropped and recorded in a sticky flag. A reset request held for too few sampled cycles is also recorded. All flags clear on the first sampled cycle of the next reset request.

A separate asynchronous power-on reset puts every register in its reset state. That reset is released through a two-stage synchronizer, and the internal reset stays active until the tail has run out.

Top module: `rst_stall_seq`

## Requirements
- R1: `rst_req_n` is sampled only on rising clock edges. The first edge that samples it low makes `core_rst` high from that edge on.
- R2: After the last edge that samples `rst_req_n` low, `core_rst` stays high for exactly two more clock cycles and then falls.
- R3: If a reset request is sampled low on fewer than two consecutive edges, `err_short_rst` is set at the edge that samples it high again.
- R4: A start strobe that arrives with no reset active, no hold, and `ready` low is not forwarded, and it sets `err_early_start`.
- R5: A start strobe that arrives while `core_rst` is high or `rst_req_n` is low is not forwarded, and it sets `err_start_in_rst`.
- R6: `hold` equals `clk_en_n` as sampled at the previous edge. While `hold` is high, the post-reset cycle count is frozen, and a start strobe is neither forwarded nor flagged as early.
- R7: The reset has priority over the enable. `core_rst` rises, stretches and falls on the same edges whatever `clk_en_n` does.
- R8: Count the edges, after `core_rst` falls, on which `core_rst` is low and `hold` is low. `ready` rises after ten such edges. The count saturates, so `ready` then stays high until the next reset.
- R9: The three error flags are sticky. They clear only at the first edge that samples a new reset request. A violation seen at that same edge is still recorded.
- R10: `exec_go` equals `exec_start` whenever `ready` is high, `hold` is low and `rst_req_n` is high. In every other case `exec_go` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low, released synchronously inside the block |
| rst_req_n | input | 1 | Synchronous reset request, active low |
| clk_en_n | input | 1 | Clock enable, active low; high requests a stall |
| exec_start | input | 1 | Execution start strobe |
| core_rst | output | 1 | Stretched internal reset for the datapath |
| hold | output | 1 | Registered global hold that freezes datapath registers |
| ready | output | 1 | High once the post-reset gap has elapsed |
| exec_go | output | 1 | Accepted start strobe forwarded to the datapath |
| err_short_rst | output | 1 | Sticky flag: reset request pulse was too short |
| err_early_start | output | 1 | Sticky flag: start came before the gap had elapsed |
| err_start_in_rst | output | 1 | Sticky flag: start came during reset |

## Verification
A wrong reset tail counter makes `core_rst` fall one cycle early or late. This is visible on the third or fourth cycle after the request is released. A gap counter that runs during a hold, wraps, or starts at the wrong edge moves the `ready` edge and changes whether a start is forwarded or flagged. This shows up within the ten-cycle window. A fault in the flag logic stays visible until the next reset request, because the flags are sticky. A hold path with the wrong latency breaks `hold` on the very next cycle after `clk_en_n` toggles.

// File: rtl/rss_pkg.sv
package rss_pkg;

  // Stretch tail after the request is released, in cycles
  localparam int unsigned TAIL_CYC_DEF = 2;
  // Minimum number of sampled low cycles in a valid request
  localparam int unsigned MIN_LOW_DEF  = 2;
  // Running cycles required between reset end and the first start
  localparam int unsigned GAP_CYC_DEF  = 10;

  // Index of each sticky error flag
  localparam int unsigned ERR_SHORT = 0;
  localparam int unsigned ERR_EARLY = 1;
  localparam int unsigned ERR_INRST = 2;
  localparam int unsigned NUM_ERR   = 3;

  typedef logic [NUM_ERR-1:0] err_vec_t;

endpackage

// File: rtl/rss_rst_sync.sv
// Two-stage synchronizer: asserts asynchronously, releases on clk.
module rss_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/rss_rst_stretch.sv
// Stretches the reset request and measures its sampled width.
module rss_rst_stretch #(
  parameter int unsigned TAIL_CYC = 2,
  parameter int unsigned MIN_LOW  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  output logic core_rst,
  output logic in_req,
  output logic first_low,
  output logic short_set
);

  localparam int unsigned TAIL_W = $clog2(TAIL_CYC + 1);
  localparam int unsigned LOW_W  = $clog2(MIN_LOW + 1);
  localparam logic [TAIL_W-1:0] TAIL_LD = TAIL_W'(TAIL_CYC);
  localparam logic [LOW_W-1:0]  LOW_MAX = LOW_W'(MIN_LOW);

  logic              rst_q, rst_d;
  logic [TAIL_W-1:0] tail_q, tail_d;
  logic [LOW_W-1:0]  low_q, low_d;

  assign in_req = ~req_n;

  // Next-state logic
  always_comb begin
    rst_d  = rst_q;
    tail_d = tail_q;
    low_d  = low_q;
    if (in_req) begin
      rst_d  = 1'b1;
      tail_d = TAIL_LD;
      if (low_q != LOW_MAX) begin
        low_d = low_q + LOW_W'(1);
      end
    end else begin
      low_d = '0;
      if (tail_q != '0) begin
        tail_d = tail_q - TAIL_W'(1);
      end else begin
        rst_d = 1'b0;
      end
    end
  end

  assign first_low = in_req & (low_q == '0);
  assign short_set = ~in_req & (low_q != '0) & (low_q < LOW_MAX);

  // State registers; the enable does not gate them (reset has priority)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b1;
      tail_q <= TAIL_LD;
      low_q  <= LOW_MAX;
    end else begin
      rst_q  <= rst_d;
      tail_q <= tail_d;
      low_q  <= low_d;
    end
  end

  assign core_rst = rst_q;

endmodule

// File: rtl/rss_gap_timer.sv
// Saturating count of running cycles after the internal reset ends.
module rss_gap_timer #(
  parameter int unsigned GAP_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic core_rst,
  input  logic hold,
  output logic ready
);

  localparam int unsigned GAP_W = $clog2(GAP_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_END = GAP_W'(GAP_CYC);

  logic [GAP_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = ~hold & (cnt_q != GAP_END);

  always_comb begin
    cnt_d = cnt_q;
    if (core_rst) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + GAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign ready = ~core_rst & (cnt_q == GAP_END);

endmodule

// File: rtl/rss_start_guard.sv
// Qualifies the start strobe and keeps the sticky protocol flags.
module rss_start_guard
  import rss_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     exec_start,
  input  logic     in_req,
  input  logic     core_rst,
  input  logic     hold,
  input  logic     ready,
  input  logic     first_low,
  input  logic     short_set,
  output logic     exec_go,
  output err_vec_t err
);

  logic     in_rst;
  err_vec_t set_v;
  err_vec_t err_q, err_d;

  assign in_rst  = core_rst | in_req;
  assign exec_go = exec_start & ready & ~hold & ~in_req;

  always_comb begin
    set_v            = '0;
    set_v[ERR_SHORT] = short_set;
    set_v[ERR_EARLY] = exec_start & ~in_rst & ~hold & ~ready;
    set_v[ERR_INRST] = exec_start & in_rst;
  end

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
    always_comb begin
      if (first_low) begin
        err_d[i] = set_v[i];
      end else begin
        err_d[i] = err_q[i] | set_v[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        err_q[i] <= 1'b0;
      end else begin
        err_q[i] <= err_d[i];
      end
    end
  end

  assign err = err_q;

endmodule

// File: rtl/rst_stall_seq.sv
module rst_stall_seq
  import rss_pkg::*;
#(
  parameter int unsigned TAIL_CYC = TAIL_CYC_DEF,
  parameter int unsigned MIN_LOW  = MIN_LOW_DEF,
  parameter int unsigned GAP_CYC  = GAP_CYC_DEF,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_req_n,
  input  logic clk_en_n,
  input  logic exec_start,
  output logic core_rst,
  output logic hold,
  output logic ready,
  output logic exec_go,
  output logic err_short_rst,
  output logic err_early_start,
  output logic err_start_in_rst
);

  logic     rst_sync_n;
  logic     in_req, first_low, short_set;
  logic     hold_q, hold_d;
  err_vec_t err;

  rss_rst_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk   (clk),
    .arst_n(arst_n),
    .rst_n (rst_sync_n)
  );

  rss_rst_stretch #(.TAIL_CYC(TAIL_CYC), .MIN_LOW(MIN_LOW)) u_stretch (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_n    (rst_req_n),
    .core_rst (core_rst),
    .in_req   (in_req),
    .first_low(first_low),
    .short_set(short_set)
  );

  // Registered hold: a disable sampled now stalls the next cycle
  assign hold_d = clk_en_n;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hold_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign hold = hold_q;

  rss_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .core_rst(core_rst),
    .hold    (hold_q),
    .ready   (ready)
  );

  rss_start_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .exec_start(exec_start),
    .in_req    (in_req),
    .core_rst  (core_rst),
    .hold      (hold_q),
    .ready     (ready),
    .first_low (first_low),
    .short_set (short_set),
    .exec_go   (exec_go),
    .err       (err)
  );

  assign err_short_rst    = err[ERR_SHORT];
  assign err_early_start  = err[ERR_EARLY];
  assign err_start_in_rst = err[ERR_INRST];

endmodule

// File: rtl/rst_stall_seq_chk.sv
module rst_stall_seq_chk (
  input logic clk,
  input logic rst_sync_n,
  input logic rst_req_n,
  input logic clk_en_n,
  input logic exec_start,
  input logic core_rst,
  input logic hold,
  input logic ready,
  input logic exec_go,
  input logic err_short_rst
);

  // Cycles since the synchronized reset released, saturating at 7
  logic [2:0] age_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end

  AST_REQ_STARTS_RST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rst_req_n |=> core_rst); // R1

  AST_TAIL_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_q >= 3'd3 && !$past(rst_req_n, 2) && $past(rst_req_n) && rst_req_n) |-> core_rst); // R2

  AST_TAIL_ENDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_q >= 3'd4 && !$past(rst_req_n, 3) && $past(rst_req_n, 2) && $past(rst_req_n) && rst_req_n)
      |=> !core_rst); // R7

  AST_HOLD_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_q >= 3'd1) |-> (hold == $past(clk_en_n))); // R6

  AST_GO_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exec_go |-> (ready && !hold && !core_rst && exec_start)); // R10

  AST_NO_GO_IN_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rst_req_n |-> !exec_go); // R5

  AST_READY_SATURATES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ready && rst_req_n) |=> ready); // R8

  AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (err_short_rst && rst_req_n) |=> err_short_rst); // R9

endmodule

bind rst_stall_seq rst_stall_seq_chk u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .rst_req_n    (rst_req_n),
  .clk_en_n     (clk_en_n),
  .exec_start   (exec_start),
  .core_rst     (core_rst),
  .hold         (hold),
  .ready        (ready),
  .exec_go      (exec_go),
  .err_short_rst(err_short_rst)
);

// File: tb/rst_stall_seq_test.sv
`timescale 1ns/1ps
module rst_stall_seq_test;

  logic clk = 1'b0;
  logic arst_n, rst_req_n, clk_en_n, exec_start;
  logic core_rst, hold, ready, exec_go;
  logic err_short_rst, err_early_start, err_start_in_rst;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  rst_stall_seq uut (
    .clk(clk), .arst_n(arst_n), .rst_req_n(rst_req_n), .clk_en_n(clk_en_n),
    .exec_start(exec_start), .core_rst(core_rst), .hold(hold), .ready(ready),
    .exec_go(exec_go), .err_short_rst(err_short_rst),
    .err_early_start(err_early_start), .err_start_in_rst(err_start_in_rst)
  );

  // Reference model built from the requirements
  logic       s1, s2;
  logic       m_rst, m_hold;
  int         m_tail, m_low, m_gap;
  logic [2:0] m_err;

  function automatic logic f_ready(logic r, int g);
    return !r && (g == 10);
  endfunction

  function automatic logic f_go(logic st, logic r, int g, logic h, logic rq_n);
    return st && f_ready(r, g) && !h && rq_n;
  endfunction

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1 <= 0; s2 <= 0;
      m_rst <= 1; m_tail <= 2; m_low <= 2; m_hold <= 0; m_gap <= 0; m_err <= '0;
    end else begin
      s1 <= 1'b1;
      s2 <= s1;
      if (!s2) begin
        m_rst <= 1; m_tail <= 2; m_low <= 2; m_hold <= 0; m_gap <= 0; m_err <= '0;
      end else begin
        logic first, in_rst;
        logic [2:0] setv;
        first  = !rst_req_n && (m_low == 0);
        in_rst = m_rst || !rst_req_n;
        setv[0] = rst_req_n && (m_low > 0) && (m_low < 2);
        setv[1] = exec_start && !in_rst && !m_hold && !f_ready(m_rst, m_gap);
        setv[2] = exec_start && in_rst;
        m_err  <= first ? setv : (m_err | setv);
        if (!rst_req_n) begin
          m_rst <= 1; m_tail <= 2; m_low <= (m_low < 2) ? m_low + 1 : 2;
        end else begin
          m_low <= 0;
          if (m_tail != 0) m_tail <= m_tail - 1;
          else m_rst <= 0;
        end
        if (m_rst) m_gap <= 0;
        else if (!m_hold && m_gap != 10) m_gap <= m_gap + 1;
        m_hold <= clk_en_n;
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1/R2/R7 core_rst", core_rst, m_rst);
    chk("R6 hold", hold, m_hold);
    chk("R8 ready", ready, f_ready(m_rst, m_gap));
    chk("R10/R5 exec_go", exec_go, f_go(exec_start, m_rst, m_gap, m_hold, rst_req_n));
    chk("R3/R9 err_short_rst", err_short_rst, m_err[0]);
    chk("R4/R9 err_early_start", err_early_start, m_err[1]);
    chk("R5/R9 err_start_in_rst", err_start_in_rst, m_err[2]);
  endtask

  // One cycle: drive at the falling edge, then compare away from the edges
  task automatic step(logic rq_n, logic en_n, logic st);
    @(negedge clk);
    rst_req_n = rq_n; clk_en_n = en_n; exec_start = st;
    #1;
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    arst_n = 0; rst_req_n = 0; clk_en_n = 0; exec_start = 0;
    repeat (3) @(negedge clk);
    #1; chk("R1 reset state core_rst", core_rst, 1'b1);
    chk("R8 reset state ready", ready, 1'b0);
    arst_n = 1;
    // R1/R2: long request, then tail of two cycles
    for (int i = 0; i < 4; i++) step(0, 0, 0);
    step(1, 0, 0);
    chk("R2 tail cycle 1", core_rst, 1'b1);
    step(1, 0, 0);
    chk("R2 tail cycle 2", core_rst, 1'b1);
    step(1, 0, 0);
    chk("R2 tail cycle 3", core_rst, 1'b1);
    step(1, 0, 0);
    chk("R2 tail over", core_rst, 1'b0);
    // R4: start inside the gap
    idle(3);
    step(1, 0, 1);
    chk("R4 early start dropped", exec_go, 1'b0);
    step(1, 0, 0);
    chk("R4 early flag", err_early_start, 1'b1);
    // R6: hold freezes the gap count
    for (int i = 0; i < 6; i++) step(1, 1, 0);
    step(1, 1, 1);
    chk("R6 start under hold dropped", exec_go, 1'b0);
    idle(12);
    chk("R8 ready after gap", ready, 1'b1);
    step(1, 0, 1);
    chk("R10 start forwarded", exec_go, 1'b1);
    idle(30);
    chk("R8 ready saturates", ready, 1'b1);
    chk("R9 early flag sticky", err_early_start, 1'b1);
    // R3/R9: one-cycle request clears then sets short flag
    step(0, 0, 0);
    step(1, 0, 0);
    chk("R9 early flag cleared", err_early_start, 1'b0);
    step(1, 0, 0);
    chk("R3 short flag", err_short_rst, 1'b1);
    // R5: start during tail; R7: tail under hold
    step(1, 1, 1);
    chk("R5 start in reset dropped", exec_go, 1'b0);
    step(1, 1, 0);
    chk("R5 in-reset flag", err_start_in_rst, 1'b1);
    step(0, 1, 0);
    step(0, 1, 0);
    for (int i = 0; i < 4; i++) step(1, 1, 0);
    chk("R7 tail ends under hold", core_rst, 1'b0);
    idle(15);
    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic rq, en, st;
      rq = ($urandom % 40) != 0;
      en = ($urandom % 6) == 0;
      st = ($urandom % 5) == 0;
      if (!rq) begin
        int len;
        len = 1 + ($urandom % 4);
        for (int j = 0; j < len; j++) step(0, en, st);
      end else begin
        step(1, en, st);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule